// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Window

This block is the software-visible control window of one bus-master disk DMA channel. Software reaches it through a 32-bit register bus with per-byte write strobes. The bus has two word slots. The low word holds the command byte in lane 0, the status byte in lane 2 and two vendor bytes in lanes 1 and 3. The high word holds the pointer to the descriptor table. The block drives a start level, a transfer direction and an aligned table base to the DMA engine. It takes back the engine's active level, a one-cycle error event from the engine and a one-cycle interrupt event from the drive.

The status byte holds three kinds of bit. The activity bit is read-only and comes from a small transfer state machine. The error and interrupt bits are sticky and are cleared by writing 1 to them. The two per-drive capability bits are plain storage. Because of this mix, the usual driver idiom works: read the status byte, OR in 0x06, and write it back. This acknowledges both flags and leaves the capability bits as they were. The interrupt output is high while the interrupt bit is set.

The state machine has four states:
- IDLE: the start bit is clear.
- ARMED: the start bit is set and the engine has not yet reported activity.
- RUN: the engine reports active. The activity bit reads 1 only in this state.
- DONE: the engine dropped active while the start bit stayed set.

The transitions are:
- IDLE→ARMED when the start bit is set.
- ARMED→RUN when the engine is active.
- RUN→DONE when the engine goes inactive.
- ARMED, RUN or DONE→IDLE when the start bit is cleared. This takes priority over every other transition.

Top module: `bmdma_regfile`

## Requirements
- R1: After reset, both words read 0, `eng_start`, `eng_to_mem` and `irq` are 0, and `tbl_base` is 0.
- R2: Command byte (low word, lane 0): bit 0 is the start bit and drives `eng_start`. Bit 3 is the direction bit and drives `eng_to_mem` (1 means the engine writes memory). All other command bits read 0. Both bits update on the clock edge of the write.
- R3: The table pointer (high word) is written per byte lane. Bits [1:0] always read 0, and `tbl_base` equals the read-back value.
- R4: The activity bit (status bit 0) reads 1 one cycle after the engine's active level is sampled while the start bit is set. It returns to 0 one cycle after active drops or after the start bit is cleared. Writes to status bit 0 have no effect.
- R5: A one-cycle `eng_err` sets status bit 1, and a one-cycle `drv_irq` sets status bit 2. Both bits stay set until they are cleared.
- R6: Writing 1 to status bit 1 or 2 clears that bit. Writing 0 leaves it unchanged. Writing (read value OR 0x06) clears both bits and keeps bits 5 and 6.
- R7: When an event arrives in the same cycle as a write-1 clear of its bit, the bit stays set.
- R8: Status bits 5 and 6 are read/write storage for drive 0 and drive 1. Status bits 3, 4 and 7 read 0.
- R9: `irq` is 1 exactly while status bit 2 is set, starting the cycle after `drv_irq`.
- R10: The vendor byte lanes 1 and 3 of the low word read 0, and writes to them change nothing.
- R11: After the engine finishes, the activity bit stays 0 while the start bit remains set, even if the engine reports active again. A clean finish therefore reads status[2:0] = 100b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_hi | input | 1 | Word slot select: 0 = control/status word, 1 = table pointer |
| bus_wr | input | 1 | Write cycle |
| bus_strb | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word |
| eng_start | output | 1 | Start level to the DMA engine |
| eng_to_mem | output | 1 | Direction: 1 = drive-to-memory |
| tbl_base | output | 32 | Dword-aligned descriptor table base |
| eng_active | input | 1 | Engine transfer-active level |
| eng_err | input | 1 | One-cycle engine error event |
| drv_irq | input | 1 | One-cycle drive interrupt event |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the status write that both acknowledges the flags and writes the capability bits. A design that applied the whole byte as plain data would either lose the capability bits or set a flag that software meant to clear. It drives an interrupt event in the same cycle as its acknowledge; if clear won over set, that interrupt would be lost. It lets the engine report active again after completion, which a design without the DONE state would misreport as a second transfer. Finally, it writes to the vendor lanes and to the low pointer bits, where a careless decoder would store data that should read as zero.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
    localparam int BUS_W      = 32;
    localparam int LANES      = BUS_W / 8;
    localparam int LANE_CMD   = 0;
    localparam int LANE_STAT  = 2;
    localparam int CMD_GO     = 0;
    localparam int CMD_DIR    = 3;
    localparam int ST_ACT     = 0;
    localparam int ST_ERR     = 1;
    localparam int ST_INT     = 2;
    localparam int ST_CAP0    = 5;
    localparam int NUM_DRIVES = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } xfer_state_t;
endpackage

// File: rtl/bmdma_xfer_fsm.sv
module bmdma_xfer_fsm
    import bmdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic eng_active,
    output logic active
);
    xfer_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!go)             state_d = ST_IDLE;
                else if (eng_active) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!go)              state_d = ST_IDLE;
                else if (!eng_active) state_d = ST_DONE;
            end
            ST_DONE:  if (!go) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb active = (state_q == ST_RUN);

    // R4: clearing start ends the reported activity one cycle later
    assert_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !go) |=> !active);
    // R4: no activity straight out of idle
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !active);
    // R11: finished transfer stays finished while start is held
    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && go) |=> (state_q == ST_DONE && !active));
endmodule

// File: rtl/bmdma_status_reg.sv
module bmdma_status_reg
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       active,
    input  logic       err_evt,
    input  logic       irq_evt,
    output logic [7:0] stat
);
    logic                  err_q;
    logic                  int_q;
    logic [NUM_DRIVES-1:0] cap_q;
    logic                  unused_bits;

    assign unused_bits = ^{wdata[7], wdata[4:3], wdata[ST_ACT]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            int_q <= 1'b0;
        end else begin
            if (err_evt)                  err_q <= 1'b1;
            else if (wr && wdata[ST_ERR]) err_q <= 1'b0;
            if (irq_evt)                  int_q <= 1'b1;
            else if (wr && wdata[ST_INT]) int_q <= 1'b0;
        end
    end

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_cap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  cap_q[d] <= 1'b0;
            else if (wr) cap_q[d] <= wdata[ST_CAP0 + d];
        end
    end

    always_comb begin
        stat = 8'h00;
        stat[ST_ACT] = active;
        stat[ST_ERR] = err_q;
        stat[ST_INT] = int_q;
        stat[ST_CAP0 +: NUM_DRIVES] = cap_q;
    end

    // R5: an error event is always captured
    assert_err_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> err_q);
    // R7: an interrupt event beats a simultaneous acknowledge
    assert_int_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_evt && wr && wdata[ST_INT]) |=> int_q);
    // R6: acknowledge without a new event clears the flag
    assert_w1c_int_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[ST_INT] && !irq_evt) |=> !int_q);
    // R8: capability bits hold without a write
    assert_cap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(cap_q));
endmodule

// File: rtl/bmdma_ptr_reg.sv
module bmdma_ptr_reg
    import bmdma_pkg::*;
#(
    parameter int ALIGN_BITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] wr_strb,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] ptr
);
    localparam logic [BUS_W-1:0] KEEP_MASK = {BUS_W{1'b1}} << ALIGN_BITS;

    logic [BUS_W-1:0] ptr_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          ptr_q[8*l +: 8] <= 8'h00;
            else if (wr_strb[l]) ptr_q[8*l +: 8] <= wdata[8*l +: 8];
        end
    end

    assign ptr = ptr_q & KEEP_MASK;

    // R3: pointer holds when no lane is written
    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strb == '0) |=> $stable(ptr));
endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
    import bmdma_pkg::*;
#(
    parameter int ALIGN_BITS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_addr_hi,
    input  logic        bus_wr,
    input  logic [3:0]  bus_strb,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        eng_start,
    output logic        eng_to_mem,
    output logic [31:0] tbl_base,
    input  logic        eng_active,
    input  logic        eng_err,
    input  logic        drv_irq,
    output logic        irq
);
    logic       go_q, dir_q;
    logic       cmd_wr, stat_wr;
    logic [3:0] ptr_strb;
    logic       active;
    logic [7:0] stat;
    logic [7:0] cmd_byte;
    logic       unused_in;

    assign cmd_wr   = bus_wr && !bus_addr_hi && bus_strb[LANE_CMD];
    assign stat_wr  = bus_wr && !bus_addr_hi && bus_strb[LANE_STAT];
    assign ptr_strb = (bus_wr && bus_addr_hi) ? bus_strb : 4'b0000;
    assign unused_in = ^{bus_wdata[2:1], bus_wdata[7:4]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_q  <= 1'b0;
            dir_q <= 1'b0;
        end else if (cmd_wr) begin
            go_q  <= bus_wdata[CMD_GO];
            dir_q <= bus_wdata[CMD_DIR];
        end
    end

    bmdma_xfer_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go_q),
        .eng_active (eng_active),
        .active     (active)
    );

    bmdma_status_reg u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (stat_wr),
        .wdata   (bus_wdata[8*LANE_STAT +: 8]),
        .active  (active),
        .err_evt (eng_err),
        .irq_evt (drv_irq),
        .stat    (stat)
    );

    bmdma_ptr_reg #(.ALIGN_BITS(ALIGN_BITS)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_strb (ptr_strb),
        .wdata   (bus_wdata),
        .ptr     (tbl_base)
    );

    always_comb begin
        cmd_byte = 8'h00;
        cmd_byte[CMD_GO]  = go_q;
        cmd_byte[CMD_DIR] = dir_q;
    end

    assign bus_rdata  = bus_addr_hi ? tbl_base : {8'h00, stat, 8'h00, cmd_byte};
    assign eng_start  = go_q;
    assign eng_to_mem = dir_q;
    assign irq        = stat[ST_INT];

    // R2: command bits only change on a command-lane write
    assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable({eng_start, eng_to_mem}));
    // R9: drive interrupt raises the line on the next cycle
    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drv_irq |=> irq);
endmodule

// File: tb/sim_bmdma_regfile.sv
module sim_bmdma_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_addr_hi = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_strb = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        eng_start, eng_to_mem, irq;
    logic [31:0] tbl_base;
    logic        eng_active = 1'b0;
    logic        eng_err = 1'b0;
    logic        drv_irq = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bmdma_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr_hi(bus_addr_hi), .bus_wr(bus_wr),
        .bus_strb(bus_strb), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_start(eng_start), .eng_to_mem(eng_to_mem), .tbl_base(tbl_base),
        .eng_active(eng_active), .eng_err(eng_err), .drv_irq(drv_irq), .irq(irq)
    );

    // behavioural reference: phase 0 idle, 1 waiting, 2 moving, 3 finished
    logic        m_go, m_dir, m_err, m_int;
    logic [1:0]  m_cap;
    logic [1:0]  m_phase, m_next;
    logic [31:0] m_ptr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_go = 0; m_dir = 0; m_err = 0; m_int = 0; m_cap = 0;
            m_phase = 0; m_ptr = 0;
        end else begin
            m_next = m_phase;
            if (!m_go) m_next = 0;
            else if (m_phase == 0) m_next = 1;
            else if (m_phase == 1 && eng_active) m_next = 2;
            else if (m_phase == 2 && !eng_active) m_next = 3;
            if (bus_wr && !bus_addr_hi && bus_strb[0]) begin
                m_go = bus_wdata[0]; m_dir = bus_wdata[3];
            end
            if (bus_wr && !bus_addr_hi && bus_strb[2]) m_cap = bus_wdata[22:21];
            if (eng_err) m_err = 1;
            else if (bus_wr && !bus_addr_hi && bus_strb[2] && bus_wdata[17]) m_err = 0;
            if (drv_irq) m_int = 1;
            else if (bus_wr && !bus_addr_hi && bus_strb[2] && bus_wdata[18]) m_int = 0;
            for (int l = 0; l < 4; l++)
                if (bus_wr && bus_addr_hi && bus_strb[l]) m_ptr[8*l +: 8] = bus_wdata[8*l +: 8];
            m_phase = m_next;
        end
    end

    function automatic logic [31:0] model_word(input logic hi);
        logic [7:0] s, c;
        s = {1'b0, m_cap, 2'b00, m_int, m_err, (m_phase == 2)};
        c = {4'b0000, m_dir, 2'b00, m_go};
        return hi ? {m_ptr[31:2], 2'b00} : {8'h00, s, 8'h00, c};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // cycle compare against the reference (all requirements)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R1-model rdata", bus_rdata, model_word(bus_addr_hi));
            check("R2-model ctrl", {30'd0, eng_start, eng_to_mem}, {30'd0, m_go, m_dir});
            check("R9-model irq", {31'd0, irq}, {31'd0, m_int});
            check("R3-model base", tbl_base, {m_ptr[31:2], 2'b00});
        end
    end

    task automatic wr(input logic hi, input logic [3:0] strb, input logic [31:0] d);
        @(posedge clk); #2;
        bus_addr_hi = hi; bus_strb = strb; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #2;
        bus_wr = 1'b0; bus_strb = 4'h0;
    endtask

    task automatic rd(input logic hi, output logic [31:0] d);
        @(posedge clk); #2;
        bus_addr_hi = hi;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic pulse_err;
        @(posedge clk); #2; eng_err = 1'b1;
        @(posedge clk); #2; eng_err = 1'b0;
    endtask

    task automatic pulse_irq;
        @(posedge clk); #2; drv_irq = 1'b1;
        @(posedge clk); #2; drv_irq = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        rd(1'b0, v); check("R1 reset word0", v, 32'h0);
        rd(1'b1, v); check("R1 reset pointer", v, 32'h0);
        check("R1 reset outputs", {29'd0, eng_start, eng_to_mem, irq}, 32'h0);

        wr(1'b1, 4'hF, 32'h1234_567F);
        rd(1'b1, v); check("R3 pointer aligned", v, 32'h1234_567C);
        check("R3 tbl_base", tbl_base, 32'h1234_567C);
        wr(1'b1, 4'b0100, 32'h00AB_0000);
        rd(1'b1, v); check("R3 lane write", v, 32'h12AB_567C);

        wr(1'b0, 4'b0001, 32'h0000_00FF);
        rd(1'b0, v); check("R2 command readback", v, 32'h0000_0009);
        check("R2 outputs", {30'd0, eng_start, eng_to_mem}, 32'd3);

        @(posedge clk); #2 eng_active = 1'b1;
        repeat (2) @(posedge clk);
        rd(1'b0, v); check("R4 active set", v, 32'h0001_0009);
        wr(1'b0, 4'b0100, 32'h0000_0000);
        rd(1'b0, v); check("R4 active bit not writable", v, 32'h0001_0009);

        @(posedge clk); #2 eng_active = 1'b0;
        repeat (2) @(posedge clk);
        rd(1'b0, v); check("R4 active clears at finish", v, 32'h0000_0009);
        @(posedge clk); #2 eng_active = 1'b1;
        repeat (3) @(posedge clk);
        rd(1'b0, v); check("R11 no restart while start held", v, 32'h0000_0009);

        pulse_err();
        pulse_irq();
        rd(1'b0, v); check("R5 flags sticky", v, 32'h0006_0009);
        check("R9 irq high", {31'd0, irq}, 32'd1);

        wr(1'b0, 4'b0100, 32'h0060_0000);
        rd(1'b0, v); check("R8 caps written flags kept", v, 32'h0066_0009);
        wr(1'b0, 4'b0100, v | 32'h0006_0000);
        rd(1'b0, v); check("R6 ack idiom", v, 32'h0060_0009);
        check("R9 irq low", {31'd0, irq}, 32'd0);
        wr(1'b0, 4'b0100, 32'h00FF_0000);
        rd(1'b0, v); check("R8 reserved bits zero", v, 32'h0060_0009);

        pulse_irq();
        @(posedge clk); #2;
        bus_addr_hi = 1'b0; bus_strb = 4'b0100; bus_wdata = 32'h0064_0000;
        bus_wr = 1'b1; drv_irq = 1'b1;
        @(posedge clk); #2;
        bus_wr = 1'b0; bus_strb = 4'h0; drv_irq = 1'b0;
        rd(1'b0, v); check("R7 event beats clear", v, 32'h0064_0009);
        check("R11 clean finish pattern", {29'd0, v[18:16]}, 32'd4);

        pulse_err();
        wr(1'b0, 4'b0100, 32'h0060_0000);
        rd(1'b0, v); check("R6 write zero keeps flags", v, 32'h0066_0009);
        wr(1'b0, 4'b0100, 32'h0062_0000);
        rd(1'b0, v); check("R6 clear err only", v, 32'h0064_0009);

        wr(1'b0, 4'b1010, 32'hFFFF_FFFF);
        rd(1'b0, v); check("R10 vendor lanes", v, 32'h0064_0009);

        wr(1'b0, 4'b0001, 32'h0000_0008);
        wr(1'b0, 4'b0001, 32'h0000_0001);
        repeat (2) @(posedge clk);
        rd(1'b0, v); check("R4 restart active", v, 32'h0065_0001);
        check("R2 direction cleared", {31'd0, eng_to_mem}, 32'd0);
        wr(1'b0, 4'b0001, 32'h0000_0000);
        rd(1'b0, v); check("R4 abort clears active", v, 32'h0064_0000);

        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule